// File: doc/BRIEF.md
# Timestamp Interrupt Coalescing Controller

This block decides when a host that drains per-channel timestamp FIFOs should be interrupted. Each channel counts the timestamps accepted since the host last serviced it. It raises a level interrupt when that count reaches a programmable count threshold. It also raises the interrupt when a programmable number of millisecond ticks has passed while at least one timestamp is waiting. The host pulses the channel's acknowledge line once it has drained the FIFO. That pulse clears the channel's pending count, its timer and its interrupt.

A separate converter error input is registered and brought out as its own interrupt line. A channel whose enable is low stays idle and silent. Threshold inputs are static configuration supplied by the surrounding register logic.

Top module: `ts_irq_coalescer`

## Requirements
- R1: Each of the NUM_CH channels keeps its own count, timer and interrupt; stimulus on one channel leaves the `irq_chan` bits of the others unchanged.
- R2: With the channel enabled, `irq_chan[i]` goes high on the clock edge at which the accepted count since the last acknowledge reaches `count_thresh`. The count saturates at its maximum instead of wrapping.
- R3: While at least one timestamp is pending, the channel timer advances on each `tick_1ms` cycle. `irq_chan[i]` goes high one clock after the tick that brings the timer to `time_thresh`.
- R4: While a channel's pending count is zero, its timer is held at zero. Ticks on an empty channel never raise its interrupt, and the timer starts from zero when the first timestamp arrives.
- R5: Once high, `irq_chan[i]` stays high until an acknowledge or a disable, whatever happens on accept or tick.
- R6: An `ts_ack[i]` pulse clears that channel's count, timer and interrupt at the next edge. An accept in the same cycle counts as the first new timestamp.
- R7: While `chan_en[i]` is low, that channel's count and timer are held at zero and its interrupt stays low. Accepts made while disabled are not remembered.
- R8: A `count_thresh` or `time_thresh` value of zero behaves as the value 1.
- R9: `irq_err` follows `conv_err` delayed by one clock.
- R10: After reset all interrupt outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chan_en | input | NUM_CH | Per-channel enable |
| ts_accept | input | NUM_CH | Single-cycle strobe: one timestamp accepted into the channel FIFO |
| ts_ack | input | NUM_CH | Single-cycle strobe: host has serviced the channel |
| tick_1ms | input | 1 | One-cycle pulse every millisecond |
| count_thresh | input | CNT_W | Timestamp-count threshold (0 treated as 1) |
| time_thresh | input | TIME_W | Timeout in milliseconds (0 treated as 1) |
| conv_err | input | 1 | Error flag from the converter |
| irq_chan | output | NUM_CH | Level interrupt per channel |
| irq_err | output | 1 | Registered converter error interrupt |

## Verification
The hardest case is a timeout on an empty channel. Ticks must arrive while nothing is pending, and afterwards the bench must show that the timer did not advance in the meantime. The bench sends several ticks into an idle channel and checks that its interrupt stays low. It then accepts one timestamp and shows that the interrupt needs the full threshold of further ticks, not fewer. The same-cycle acknowledge-plus-accept case is driven directly. With a threshold of two, only one further accept then raises the interrupt.

// File: rtl/ts_irq_pkg.sv
package ts_irq_pkg;

    typedef struct packed {
        logic en;
        logic accept;
        logic ack;
        logic tick;
    } chan_ctl_t;

    function automatic logic [15:0] eff_thresh(input logic [15:0] raw);
        return (raw == 16'd0) ? 16'd1 : raw;
    endfunction

endpackage

// File: rtl/ts_irq_chan.sv
module ts_irq_chan
    import ts_irq_pkg::*;
#(
    parameter int CNT_W  = 10,
    parameter int TIME_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  chan_ctl_t         ctl,
    input  logic [CNT_W-1:0]  cnt_thr,
    input  logic [TIME_W-1:0] tmo_thr,
    output logic              irq
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0]  cnt_q, cnt_nx;
    logic [TIME_W-1:0] tmr_q, tmr_nx;
    logic              irq_q, irq_nx;
    logic              cnt_hit, tmo_hit;

    always_comb begin
        if (ctl.ack)
            cnt_nx = ctl.accept ? CNT_W'(1) : '0;
        else if (ctl.accept && cnt_q != CNT_MAX)
            cnt_nx = cnt_q + CNT_W'(1);
        else
            cnt_nx = cnt_q;

        if (ctl.ack || cnt_q == '0)
            tmr_nx = '0;
        else if (ctl.tick && tmr_q < tmo_thr)
            tmr_nx = tmr_q + TIME_W'(1);
        else
            tmr_nx = tmr_q;

        cnt_hit = (cnt_nx >= cnt_thr);
        tmo_hit = (cnt_q != '0) && (tmr_q >= tmo_thr);
        irq_nx  = ctl.ack ? 1'b0 : (irq_q | cnt_hit | tmo_hit);
    end

    always_ff @(posedge clk) begin
        if (rst || !ctl.en) begin
            cnt_q <= '0;
            tmr_q <= '0;
            irq_q <= 1'b0;
        end else begin
            cnt_q <= cnt_nx;
            tmr_q <= tmr_nx;
            irq_q <= irq_nx;
        end
    end

    assign irq = irq_q;

    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (rst)
        !ctl.en |=> !irq_q); // R7
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
        ctl.ack |=> !irq_q); // R6
    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (rst)
        (irq_q && ctl.en && !ctl.ack) |=> irq_q); // R5
    AST_NO_EMPTY_IRQ: assert property (@(posedge clk) disable iff (rst)
        irq_q |-> (cnt_q != '0)); // R4
    AST_EMPTY_TIMER_IDLE: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == '0) |=> (tmr_q == '0)); // R4
    AST_CNT_SATURATES: assert property (@(posedge clk) disable iff (rst)
        (ctl.en && !ctl.ack && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX)); // R2

endmodule

// File: rtl/ts_irq_coalescer.sv
module ts_irq_coalescer
    import ts_irq_pkg::*;
#(
    parameter int NUM_CH = 5,
    parameter int CNT_W  = 10,
    parameter int TIME_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] chan_en,
    input  logic [NUM_CH-1:0] ts_accept,
    input  logic [NUM_CH-1:0] ts_ack,
    input  logic              tick_1ms,
    input  logic [CNT_W-1:0]  count_thresh,
    input  logic [TIME_W-1:0] time_thresh,
    input  logic              conv_err,
    output logic [NUM_CH-1:0] irq_chan,
    output logic              irq_err
);
    logic [15:0]       cnt_wide, tmo_wide;
    logic [CNT_W-1:0]  cnt_eff;
    logic [TIME_W-1:0] tmo_eff;
    logic              err_q;

    assign cnt_wide = eff_thresh(16'(count_thresh));
    assign tmo_wide = eff_thresh(16'(time_thresh));
    assign cnt_eff  = cnt_wide[CNT_W-1:0];
    assign tmo_eff  = tmo_wide[TIME_W-1:0];

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
        chan_ctl_t ctl;
        assign ctl = '{en: chan_en[i], accept: ts_accept[i], ack: ts_ack[i], tick: tick_1ms};
        ts_irq_chan #(.CNT_W(CNT_W), .TIME_W(TIME_W)) u_chan (
            .clk     (clk),
            .rst     (rst),
            .ctl     (ctl),
            .cnt_thr (cnt_eff),
            .tmo_thr (tmo_eff),
            .irq     (irq_chan[i])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) err_q <= 1'b0;
        else     err_q <= conv_err;
    end
    assign irq_err = err_q;

    AST_ERR_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        conv_err |=> irq_err); // R9
    AST_ERR_DROPS: assert property (@(posedge clk) disable iff (rst)
        !conv_err |=> !irq_err); // R9

endmodule

// File: tb/ts_irq_coalescer_test.sv
module ts_irq_coalescer_test;
    localparam int NCH = 5;
    localparam int CW  = 4;
    localparam int TW  = 4;

    logic           clk = 0;
    logic           rst = 1;
    logic [NCH-1:0] chan_en = '1;
    logic [NCH-1:0] ts_accept = '0;
    logic [NCH-1:0] ts_ack = '0;
    logic           tick_1ms = 0;
    logic [CW-1:0]  count_thresh = 4'd15;
    logic [TW-1:0]  time_thresh = 4'd15;
    logic           conv_err = 0;
    logic [NCH-1:0] irq_chan;
    logic           irq_err;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    ts_irq_coalescer #(.NUM_CH(NCH), .CNT_W(CW), .TIME_W(TW)) uut (
        .clk(clk), .rst(rst), .chan_en(chan_en), .ts_accept(ts_accept),
        .ts_ack(ts_ack), .tick_1ms(tick_1ms), .count_thresh(count_thresh),
        .time_thresh(time_thresh), .conv_err(conv_err),
        .irq_chan(irq_chan), .irq_err(irq_err));

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc(input logic [NCH-1:0] acc, input logic [NCH-1:0] ak, input logic tk);
        ts_accept = acc; ts_ack = ak; tick_1ms = tk;
        @(negedge clk);
        ts_accept = '0; ts_ack = '0; tick_1ms = 0;
    endtask

    task automatic t_reset();
        chk("R10 irq_chan after reset", 8'(irq_chan), 8'h00);
        chk("R10 irq_err after reset", 8'(irq_err), 8'h00);
    endtask

    task automatic t_count();
        count_thresh = 4'd3; time_thresh = 4'd15;
        cyc(5'b00001, '0, 0);
        cyc(5'b00001, '0, 0);
        chk("R2 below count threshold", 8'(irq_chan), 8'h00);
        cyc(5'b00001, '0, 0);
        chk("R2 count threshold reached", 8'(irq_chan), 8'h01);
        chk("R1 other channels untouched", 8'(irq_chan[4:1]), 8'h00);
        cyc('0, '0, 1); cyc(5'b00001, '0, 0); cyc('0, '0, 0);
        chk("R5 level held until ack", 8'(irq_chan), 8'h01);
        cyc('0, 5'b00001, 0);
        chk("R6 ack clears irq", 8'(irq_chan), 8'h00);
    endtask

    task automatic t_timeout();
        count_thresh = 4'd15; time_thresh = 4'd3;
        cyc(5'b00010, '0, 0);
        cyc('0, '0, 1); cyc('0, '0, 1); cyc('0, '0, 0);
        chk("R3 before timeout", 8'(irq_chan), 8'h00);
        cyc('0, '0, 1); cyc('0, '0, 0);
        chk("R3 timeout with pending", 8'(irq_chan), 8'h02);
        cyc('0, 5'b00010, 0);
        chk("R6 ack clears timeout irq", 8'(irq_chan), 8'h00);
    endtask

    task automatic t_empty();
        count_thresh = 4'd15; time_thresh = 4'd3;
        for (int k = 0; k < 6; k++) cyc('0, '0, 1);
        cyc('0, '0, 0);
        chk("R4 empty channel no timeout irq", 8'(irq_chan), 8'h00);
        cyc(5'b00100, '0, 0);
        cyc('0, '0, 1); cyc('0, '0, 1); cyc('0, '0, 0);
        chk("R4 timer started from zero", 8'(irq_chan), 8'h00);
        cyc('0, '0, 1); cyc('0, '0, 0);
        chk("R4 timeout after full window", 8'(irq_chan), 8'h04);
        cyc('0, 5'b00100, 0);
    endtask

    task automatic t_ack_same();
        count_thresh = 4'd2; time_thresh = 4'd15;
        cyc(5'b01000, '0, 0);
        cyc(5'b01000, 5'b01000, 0);
        chk("R6 ack with accept leaves irq low", 8'(irq_chan), 8'h00);
        cyc(5'b01000, '0, 0);
        chk("R6 same-cycle accept counted", 8'(irq_chan), 8'h08);
        cyc('0, 5'b01000, 0);
    endtask

    task automatic t_disable();
        count_thresh = 4'd2; time_thresh = 4'd15;
        chan_en = 5'b01111;
        cyc(5'b10000, '0, 0); cyc(5'b10000, '0, 0); cyc(5'b10000, '0, 1);
        chk("R7 disabled channel silent", 8'(irq_chan), 8'h00);
        chan_en = '1;
        cyc(5'b10000, '0, 0);
        chk("R7 accepts while disabled not kept", 8'(irq_chan), 8'h00);
        cyc(5'b10000, '0, 0);
        chk("R7 counting after enable", 8'(irq_chan), 8'h10);
        chan_en = 5'b01111;
        cyc('0, '0, 0);
        chk("R7 disable drops irq", 8'(irq_chan), 8'h00);
        chan_en = '1;
    endtask

    task automatic t_zero_thr();
        count_thresh = 4'd0; time_thresh = 4'd15;
        cyc(5'b00001, '0, 0);
        chk("R8 zero count threshold acts as 1", 8'(irq_chan), 8'h01);
        cyc('0, 5'b00001, 0);
        count_thresh = 4'd15; time_thresh = 4'd0;
        cyc(5'b00010, '0, 0); cyc('0, '0, 0);
        chk("R8 zero time threshold needs one tick", 8'(irq_chan), 8'h00);
        cyc('0, '0, 1); cyc('0, '0, 0);
        chk("R8 zero time threshold acts as 1", 8'(irq_chan), 8'h02);
        cyc('0, 5'b00010, 0);
    endtask

    task automatic t_error();
        conv_err = 1;
        chk("R9 irq_err not yet", 8'(irq_err), 8'h00);
        @(negedge clk);
        chk("R9 irq_err follows", 8'(irq_err), 8'h01);
        conv_err = 0;
        @(negedge clk);
        chk("R9 irq_err drops", 8'(irq_err), 8'h00);
        chk("R1 channels unaffected by error", 8'(irq_chan), 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_count();
        t_timeout();
        t_empty();
        t_ack_same();
        t_disable();
        t_zero_thr();
        t_error();
        done = 1;
    end

    initial begin
        for (int n = 0; n < 20000 && !done; n++) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=complete");
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule